// File: doc/BRIEF.md
# UART FIFO Interrupt Mode Controller

This block decides when a UART with 16-entry transmit and receive FIFOs raises its interrupt request. It also produces the two transmitter flags of the line status register. It does not store data. It looks at the occupancy counts that the FIFO logic reports, the shift-register busy flag, the programmed receive trigger field, the two source enables, the FIFO enable and the mode bit. From these it computes one registered interrupt line and two registered status bits.

Two interrupt policies exist, and a single mode bit picks between them.

- **Character mode.** The line is raised whenever the receiver holds any character or the transmit path has drained. Software then services one character at a time.
- **Block mode.** The line is raised on thresholds: the transmit FIFO has any free slot, or the receive FIFO holds more characters than the trigger level. Software can then move a burst per service. Block mode only takes effect while the FIFOs are enabled.

Top module: `uart_fifo_irq_ctrl`

## Requirements
- R1: Synchronous active-low reset drives `irq` to 0, `lsr_thr_room` to 1 and `lsr_tx_idle` to 1 at the first rising edge with `rst_n` low.
- R2: In character mode, the receive source is pending whenever `rx_count` is 1 or more.
- R3: In character mode, the transmit source is pending whenever `tx_count` is 0.
- R4: In block mode (`fifo_en`=1, `dma_mode`=1), the transmit source is pending while `tx_count` is below 16. It stops being pending once `tx_count` reaches 16.
- R5: In block mode, the receive source is pending while `rx_count` is strictly greater than the trigger level. It clears when `rx_count` falls to the level or below it.
- R6: The `rx_trig_sel` encoding sets the trigger level as follows: 0 gives 1 character, 1 gives 4, 2 gives 8 and 3 gives 14.
- R7: `ier_tx` gates the transmit source and `ier_rx` gates the receive source. `irq` is the OR of the enabled pending sources. With both enables low, `irq` stays 0.
- R8: While `fifo_en`=0, `dma_mode` has no effect, and the block follows the character-mode rules.
- R9: `lsr_thr_room` is 1 when `tx_count` is below 16 with the FIFOs enabled. With the FIFOs disabled, it is 1 only when `tx_count` is 0.
- R10: `lsr_tx_idle` is 1 exactly when `tx_count` is 0 and `tsr_busy` is 0.
- R11: All three outputs are registered. Each one reflects the inputs sampled at the previous rising edge, so an input change is visible one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled |
| dma_mode | input | 1 | 0 = character mode, 1 = block mode |
| rx_trig_sel | input | 2 | Receive trigger level select (0:1, 1:4, 2:8, 3:14) |
| ier_tx | input | 1 | Transmit interrupt enable |
| ier_rx | input | 1 | Receive interrupt enable |
| tx_count | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| rx_count | input | 5 | Receive FIFO occupancy, 0 to 16 |
| tsr_busy | input | 1 | Transmit shift register still shifting |
| irq | output | 1 | Interrupt request |
| lsr_thr_room | output | 1 | Line status bit 5: the transmit path has a free slot |
| lsr_tx_idle | output | 1 | Line status bit 6: the FIFO and the shift register are both empty |

## Verification
Every output is a single register fed by the present inputs. A fault in the mode selection, the trigger decode or the source gating therefore appears on `irq` at the rising edge that follows the stimulus. It never appears later, and no earlier history can mask it.

The threshold boundaries are the sensitive points. Examples are `rx_count` equal to the trigger level against one above it, and `tx_count` of 15 against 16. An off-by-one comparator or a swapped trigger code flips `irq` at exactly one of these counts. Status flags that are wrong show up in the same cycle on `lsr_thr_room` or `lsr_tx_idle`.

// File: rtl/uart_irq_pkg.sv
// Shared types for the UART FIFO interrupt controller.
// Assumes: occupancy counts are unsigned and never exceed the FIFO depth.
package uart_irq_pkg;

    // Receive trigger select codes; the numeric value is the register field.
    typedef enum logic [1:0] {
        TRIG_SEL_LO   = 2'd0,
        TRIG_SEL_MLO  = 2'd1,
        TRIG_SEL_MHI  = 2'd2,
        TRIG_SEL_HI   = 2'd3
    } trig_sel_e;

    // Index of each interrupt source in the pending/enable vectors.
    localparam int SRC_TX  = 0;
    localparam int SRC_RX  = 1;
    localparam int NUM_SRC = 2;

endpackage

// File: rtl/uart_rx_trig_decode.sv
// Receive trigger level decoder.
// Maps the 2-bit select field onto a character count threshold.
// Assumes: the level parameters fit in CNT_W bits.
module uart_rx_trig_decode
    import uart_irq_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int LVL_0  = 1,
    parameter int LVL_1  = 4,
    parameter int LVL_2  = 8,
    parameter int LVL_3  = 14
) (
    input  trig_sel_e          sel,
    output logic [CNT_W-1:0]   level
);

    // Select the threshold for the programmed code.
    always_comb begin
        unique case (sel)
            TRIG_SEL_LO:  level = CNT_W'(LVL_0);
            TRIG_SEL_MLO: level = CNT_W'(LVL_1);
            TRIG_SEL_MHI: level = CNT_W'(LVL_2);
            default:      level = CNT_W'(LVL_3);
        endcase
    end

endmodule

// File: rtl/uart_irq_src_eval.sv
// Interrupt source evaluator.
// Produces the raw (ungated) transmit and receive pending conditions for
// either the per-character policy or the block threshold policy.
// Assumes: counts lie in 0..FIFO_DEPTH; block_mode is already qualified by
// the FIFO enable.
module uart_irq_src_eval
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               block_mode,
    input  logic [CNT_W-1:0]   tx_count,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic [CNT_W-1:0]   rx_level,
    output logic [NUM_SRC-1:0] pend
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

    logic chr_tx, chr_rx, blk_tx, blk_rx;

    // Per-character conditions: drained transmitter, any received character.
    always_comb begin
        chr_tx = (tx_count == '0);
        chr_rx = (rx_count != '0);
    end

    // Block conditions: free transmit slot, receive occupancy above trigger.
    always_comb begin
        blk_tx = (tx_count < FULL_CNT);
        blk_rx = (rx_count > rx_level);
    end

    // Pick the policy selected by the mode bit.
    always_comb begin
        pend         = '0;
        pend[SRC_TX] = block_mode ? blk_tx : chr_tx;
        pend[SRC_RX] = block_mode ? blk_rx : chr_rx;
    end

endmodule

// File: rtl/uart_tx_line_status.sv
// Transmitter line status flags (room available, fully idle).
// Registered; reset reports an empty, idle transmitter.
// Assumes: with FIFOs disabled the transmit path is a single holding slot.
module uart_tx_line_status #(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             tsr_busy,
    output logic             room_q,
    output logic             idle_q
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

    logic room_d, idle_d;

    // Free slot: below depth in FIFO mode, empty holding slot otherwise.
    always_comb begin
        room_d = fifo_en ? (tx_count < FULL_CNT) : (tx_count == '0);
        idle_d = (tx_count == '0) && !tsr_busy;
    end

    // Register both flags with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            room_q <= 1'b1;
            idle_q <= 1'b1;
        end else begin
            room_q <= room_d;
            idle_q <= idle_d;
        end
    end

endmodule

// File: rtl/uart_fifo_irq_ctrl.sv
// UART FIFO interrupt mode controller (top).
// Combines the trigger decode, the source evaluator and the enable gating
// into one registered interrupt line, plus the transmitter status flags.
// Assumes: counts come from the FIFO logic in the same clock domain.
module uart_fifo_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_0      = 1,
    parameter int LVL_1      = 4,
    parameter int LVL_2      = 8,
    parameter int LVL_3      = 14,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             dma_mode,
    input  logic [1:0]       rx_trig_sel,
    input  logic             ier_tx,
    input  logic             ier_rx,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             tsr_busy,
    output logic             irq,
    output logic             lsr_thr_room,
    output logic             lsr_tx_idle
);

    logic               block_mode;
    logic [CNT_W-1:0]   rx_level;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] ena;
    logic [NUM_SRC-1:0] gated;
    logic               irq_d;

    // Block mode only applies while the FIFOs are enabled.
    always_comb block_mode = fifo_en & dma_mode;

    // Gather the enable bits into source order.
    always_comb begin
        ena         = '0;
        ena[SRC_TX] = ier_tx;
        ena[SRC_RX] = ier_rx;
    end

    uart_rx_trig_decode #(
        .CNT_W (CNT_W),
        .LVL_0 (LVL_0),
        .LVL_1 (LVL_1),
        .LVL_2 (LVL_2),
        .LVL_3 (LVL_3)
    ) u_trig (
        .sel   (trig_sel_e'(rx_trig_sel)),
        .level (rx_level)
    );

    uart_irq_src_eval #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .CNT_W      (CNT_W)
    ) u_src (
        .block_mode (block_mode),
        .tx_count   (tx_count),
        .rx_count   (rx_count),
        .rx_level   (rx_level),
        .pend       (pend)
    );

    // Gate each source by its own enable.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_gate
        always_comb gated[s] = pend[s] & ena[s];
    end

    // Any enabled pending source requests service.
    always_comb irq_d = |gated;

    // Register the interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= irq_d;
    end

    uart_tx_line_status #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .CNT_W      (CNT_W)
    ) u_lsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .tx_count (tx_count),
        .tsr_busy (tsr_busy),
        .room_q   (lsr_thr_room),
        .idle_q   (lsr_tx_idle)
    );

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
// Assertion checker for uart_fifo_irq_ctrl, attached by bind.
// Relates each registered output to the inputs of the previous cycle.
module uart_irq_ctrl_chk #(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             dma_mode,
    input logic             ier_tx,
    input logic             ier_rx,
    input logic [CNT_W-1:0] tx_count,
    input logic             tsr_busy,
    input logic             irq,
    input logic             lsr_thr_room,
    input logic             lsr_tx_idle
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

    logic past_ok;

    // Marks that the previous edge was outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_TX_EMPTY_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(ier_tx && tx_count == '0) |-> irq); // R3

    AST_BLOCK_TX_ROOM_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(fifo_en && dma_mode && ier_tx && tx_count < FULL_CNT) |-> irq); // R4

    AST_NO_ENABLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!ier_tx && !ier_rx) |-> !irq); // R7

    AST_FIFO_OFF_NO_BLOCK_TX: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!fifo_en && !ier_rx && tx_count != '0) |-> !irq); // R8

    AST_IDLE_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_tx_idle |-> lsr_thr_room); // R9

    AST_IDLE_TRACKS_SHIFTER: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> lsr_tx_idle == $past(tx_count == '0 && !tsr_busy)); // R10

endmodule

bind uart_fifo_irq_ctrl uart_irq_ctrl_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_en      (fifo_en),
    .dma_mode     (dma_mode),
    .ier_tx       (ier_tx),
    .ier_rx       (ier_rx),
    .tx_count     (tx_count),
    .tsr_busy     (tsr_busy),
    .irq          (irq),
    .lsr_thr_room (lsr_thr_room),
    .lsr_tx_idle  (lsr_tx_idle)
);

// File: tb/test_uart_fifo_irq_ctrl.sv
// Self-checking bench: vector table walk, then directed reset/latency tests.
module test_uart_fifo_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic       dma_mode = 1'b0;
    logic [1:0] rx_trig_sel = 2'd0;
    logic       ier_tx = 1'b0;
    logic       ier_rx = 1'b0;
    logic [4:0] tx_count = 5'd0;
    logic [4:0] rx_count = 5'd0;
    logic       tsr_busy = 1'b0;
    logic       irq, lsr_thr_room, lsr_tx_idle;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    uart_fifo_irq_ctrl i_uart_fifo_irq_ctrl (
        .clk, .rst_n, .fifo_en, .dma_mode, .rx_trig_sel, .ier_tx, .ier_rx,
        .tx_count, .rx_count, .tsr_busy, .irq, .lsr_thr_room, .lsr_tx_idle
    );

    // Vector: {req[3:0], fifo_en, dma, ier_tx, ier_rx, trig[1:0], tx[4:0],
    //          rx[4:0], busy, exp_irq, exp_room, exp_idle}  = 24 bits
    localparam int NV = 22;
    localparam logic [23:0] VEC [0:NV-1] = '{
        {4'd2,  1'b1,1'b0,1'b0,1'b1,2'd0,5'd16,5'd1, 1'b0, 1'b1,1'b0,1'b0}, // R2 one rx char
        {4'd2,  1'b1,1'b0,1'b0,1'b1,2'd0,5'd16,5'd0, 1'b0, 1'b0,1'b0,1'b0}, // R2 rx empty
        {4'd3,  1'b1,1'b0,1'b1,1'b0,2'd0,5'd0, 5'd0, 1'b1, 1'b1,1'b1,1'b0}, // R3 tx drained, shifter busy
        {4'd3,  1'b1,1'b0,1'b1,1'b0,2'd0,5'd5, 5'd0, 1'b0, 1'b0,1'b1,1'b0}, // R3 tx not empty
        {4'd4,  1'b1,1'b1,1'b1,1'b0,2'd0,5'd15,5'd0, 1'b0, 1'b1,1'b1,1'b0}, // R4 one free slot
        {4'd4,  1'b1,1'b1,1'b1,1'b0,2'd0,5'd16,5'd0, 1'b0, 1'b0,1'b0,1'b0}, // R4 full clears
        {4'd4,  1'b1,1'b1,1'b1,1'b0,2'd0,5'd3, 5'd0, 1'b0, 1'b1,1'b1,1'b0}, // R4 partly filled
        {4'd5,  1'b1,1'b1,1'b0,1'b1,2'd1,5'd16,5'd4, 1'b0, 1'b0,1'b0,1'b0}, // R5 at level
        {4'd5,  1'b1,1'b1,1'b0,1'b1,2'd1,5'd16,5'd5, 1'b0, 1'b1,1'b0,1'b0}, // R5 above level
        {4'd5,  1'b1,1'b1,1'b0,1'b1,2'd1,5'd16,5'd3, 1'b0, 1'b0,1'b0,1'b0}, // R5 drops below
        {4'd6,  1'b1,1'b1,1'b0,1'b1,2'd0,5'd16,5'd1, 1'b0, 1'b0,1'b0,1'b0}, // R6 code 0 level 1
        {4'd6,  1'b1,1'b1,1'b0,1'b1,2'd0,5'd16,5'd2, 1'b0, 1'b1,1'b0,1'b0}, // R6
        {4'd6,  1'b1,1'b1,1'b0,1'b1,2'd2,5'd16,5'd8, 1'b0, 1'b0,1'b0,1'b0}, // R6 code 2 level 8
        {4'd6,  1'b1,1'b1,1'b0,1'b1,2'd2,5'd16,5'd9, 1'b0, 1'b1,1'b0,1'b0}, // R6
        {4'd6,  1'b1,1'b1,1'b0,1'b1,2'd3,5'd16,5'd14,1'b0, 1'b0,1'b0,1'b0}, // R6 code 3 level 14
        {4'd6,  1'b1,1'b1,1'b0,1'b1,2'd3,5'd16,5'd15,1'b0, 1'b1,1'b0,1'b0}, // R6
        {4'd7,  1'b1,1'b1,1'b0,1'b0,2'd3,5'd0, 5'd16,1'b0, 1'b0,1'b1,1'b1}, // R7 all sources masked
        {4'd7,  1'b1,1'b1,1'b1,1'b1,2'd3,5'd16,5'd15,1'b0, 1'b1,1'b0,1'b0}, // R7 OR, rx only
        {4'd8,  1'b0,1'b1,1'b1,1'b0,2'd0,5'd0, 5'd0, 1'b0, 1'b1,1'b1,1'b1}, // R8 fifo off, tx empty
        {4'd8,  1'b0,1'b1,1'b1,1'b0,2'd0,5'd1, 5'd0, 1'b0, 1'b0,1'b0,1'b0}, // R8 R9 mode bit ignored
        {4'd8,  1'b0,1'b1,1'b0,1'b1,2'd3,5'd1, 5'd1, 1'b0, 1'b1,1'b0,1'b0}, // R8 rx per char
        {4'd10, 1'b1,1'b0,1'b0,1'b0,2'd0,5'd0, 5'd0, 1'b0, 1'b0,1'b1,1'b1}  // R10 fully idle
    };

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {irq,room,idle} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [23:0] v);
        fifo_en     = v[19];
        dma_mode    = v[18];
        ier_tx      = v[17];
        ier_rx      = v[16];
        rx_trig_sel = v[15:14];
        tx_count    = v[13:9];
        rx_count    = v[8:4];
        tsr_busy    = v[3];
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset values after a clocked reset.
        repeat (3) @(negedge clk);
        check("R1 reset", {irq, lsr_thr_room, lsr_tx_idle}, 3'b011);
        rst_n = 1'b1;

        // Table walk: drive at a falling edge, sample at the next falling edge.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i][23:20], i),
                  {irq, lsr_thr_room, lsr_tx_idle}, VEC[i][2:0]);
        end

        // R11: output holds until the next edge, then follows.
        @(negedge clk);
        fifo_en = 1'b1; dma_mode = 1'b1; ier_tx = 1'b1; ier_rx = 1'b0;
        tx_count = 5'd16; tsr_busy = 1'b1;
        @(negedge clk);
        check("R11 settle", {irq, lsr_thr_room, lsr_tx_idle}, 3'b000);
        tx_count = 5'd0; tsr_busy = 1'b0;
        #1;
        check("R11 before edge", {irq, lsr_thr_room, lsr_tx_idle}, 3'b000);
        @(negedge clk);
        check("R11 after edge", {irq, lsr_thr_room, lsr_tx_idle}, 3'b111);

        // R1: reset taken while irq is high clears it.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears irq", {irq, lsr_thr_room, lsr_tx_idle}, 3'b011);
        rst_n = 1'b1;
        tx_count = 5'd7; tsr_busy = 1'b1;
        @(negedge clk);
        check("R4 after reset release", {irq, lsr_thr_room, lsr_tx_idle}, 3'b110);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule